// File: doc/BRIEF.md
# Branch Direction Table with Static Fallback

This block predicts the direction of conditional branches. It holds a direct-mapped table of small entries. Each entry has a trained flag and a two-bit saturating confidence counter. The index into the table comes from the branch address with its lowest bit dropped, taken modulo the entry count. No tag is stored, so branches whose addresses alias to the same slot share one entry.

The lookup side is purely combinational. It presents a branch address and the branch's sign-extended displacement, and it receives a taken/not-taken guess in the same cycle.

- If the selected entry has been trained, the counter decides: values 2 and 3 predict taken.
- If the entry has never been trained, a static rule applies: a backward branch (negative displacement) is predicted taken and a forward branch is predicted not-taken.

The update side is driven when a branch retires. It carries the branch address and the resolved outcome. The commit logic feeding this port derives the outcome by comparing the next retired address with the branch's fall-through address.

An update marks the entry trained and moves the counter one step toward the outcome, saturating at both ends. The write lands on the clock edge. A lookup to the same slot in the same cycle therefore sees the old contents.

Top module: `bht_predictor`

## Requirements
- R1: The slot used by either port is (address >> 1) mod ENTRIES. Address bit 0 and the bits above the index field do not change which slot is used, so addresses differing only there alias.
- R2: After synchronous reset every slot is untrained, with a counter value of 0.
- R3: For an untrained slot, lk_taken equals bit OFF_W-1 (the sign bit) of lk_offset.
- R4: For a trained slot, lk_taken is 1 exactly when the counter is 2 or 3, whatever the sign of lk_offset.
- R5: An update marks its slot trained. The first taken update from reset leaves the counter at 1, so a backward branch to that slot is then predicted not-taken.
- R6: A taken update increments the counter and saturates at 3.
- R7: A not-taken update decrements the counter and saturates at 0. A trained slot at 0 stays trained.
- R8: An update changes only the slot it indexes.
- R9: An update is visible to lookups from the cycle after its clock edge. A lookup of the same slot in the cycle the update is presented sees the pre-update contents.
- R10: Asserting rst while slots are trained returns every slot to untrained with a counter of 0.
- R11: While upd_en is 0, upd_addr and upd_taken have no effect on any slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Address of the branch being looked up |
| lk_offset | input | OFF_W | Sign-extended branch displacement |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_en | input | 1 | Update strobe from the retire stage |
| upd_addr | input | ADDR_W | Address of the retiring branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The lookup result is combinational, so it is due in the same cycle as the lookup inputs. The bench changes lk_addr and lk_offset just after a falling edge and samples lk_taken one time unit later.

An update takes effect at the rising edge on which upd_en is high. The bench applies an update in its reference model only at that edge and checks the new prediction after it. For the same-slot collision, the bench checks once before that edge, expecting the old value, and once after it, expecting the new one.

Reset clears the table at the first rising edge with rst high. The untrained checks are therefore made only after rst has been released.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // Two-bit confidence counter; the upper half predicts taken
    typedef enum logic [1:0] {
        CONF_STRONG_NT = 2'd0,
        CONF_WEAK_NT   = 2'd1,
        CONF_WEAK_T    = 2'd2,
        CONF_STRONG_T  = 2'd3
    } conf_t;

    typedef struct packed {
        logic  trained;
        conf_t conf;
    } slot_t;

    // Saturating step of the counter toward the resolved outcome
    function automatic conf_t conf_step(conf_t cur, logic taken);
        conf_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CONF_STRONG_T) nxt = conf_t'(cur + 2'd1);
        end else begin
            if (cur != CONF_STRONG_NT) nxt = conf_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Direction guess: counter when trained, else backward-taken rule
    function automatic logic slot_guess(slot_t s, logic backward);
        if (s.trained) return s.conf[1];
        return backward;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    localparam bit IS_POW2 = (ENTRIES & (ENTRIES - 1)) == 0;

    generate
        if (IS_POW2 && ENTRIES > 1) begin : g_slice
            // Power-of-two table: the modulo is a plain bit slice
            logic unused_addr_bits;
            assign unused_addr_bits = ^{addr[ADDR_W-1:IDX_W+1], addr[0]};
            assign idx = addr[IDX_W:1];
        end else begin : g_mod
            logic [ADDR_W-1:0] half;
            logic [ADDR_W-1:0] rem;
            assign half = addr >> 1;
            assign rem  = half % ADDR_W'(ENTRIES);
            assign idx  = rem[IDX_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [ENTRIES-1:0]      trained_q;
    logic [ENTRIES-1:0][1:0] conf_q;

    assign rd_slot.trained = trained_q[rd_idx];
    assign rd_slot.conf    = conf_t'(conf_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            trained_q <= '0;
            conf_q    <= '0;
        end else if (wr_en) begin
            trained_q[wr_idx] <= 1'b1;
            conf_q[wr_idx]    <= conf_step(conf_t'(conf_q[wr_idx]), wr_taken);
        end
    end

    // Checker state: slot written in the previous cycle
    logic [IDX_W-1:0] prev_idx_q;
    always_ff @(posedge clk) prev_idx_q <= wr_idx;

    AST_SAT_UP: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && conf_q[wr_idx] == 2'd3 |=> conf_q[prev_idx_q] == 2'd3); // R6
    AST_SAT_DN: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && conf_q[wr_idx] == 2'd0 |=> conf_q[prev_idx_q] == 2'd0); // R7
    AST_MARK_TRAINED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> trained_q[prev_idx_q]); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(trained_q) && $stable(conf_q)); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> trained_q == '0 && conf_q == '0); // R10

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 32,
    parameter int ENTRIES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [OFF_W-1:0]  lk_offset,
    output logic              lk_taken,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    slot_t            lk_slot;
    logic             backward;
    logic             unused_offset_bits;

    assign backward           = lk_offset[OFF_W-1];
    assign unused_offset_bits = ^lk_offset[OFF_W-2:0];

    bht_index #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lk_index (
        .addr (lk_addr),
        .idx  (lk_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_upd_index (
        .addr (upd_addr),
        .idx  (upd_idx)
    );

    bht_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_slot  (lk_slot),
        .wr_en    (upd_en),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    assign lk_taken = slot_guess(lk_slot, backward);

    AST_UNTRAINED_STATIC: assert property (@(posedge clk) disable iff (rst)
        !lk_slot.trained |-> lk_taken == lk_offset[OFF_W-1]); // R3

endmodule

// File: tb/tb_bht_predictor.sv
module tb_bht_predictor;

    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 32;
    localparam int ENTRIES = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [OFF_W-1:0]  lk_offset = '0;
    logic              lk_taken;
    logic              upd_en = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_taken = 1'b0;

    always #5 clk = ~clk;

    bht_predictor #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_offset(lk_offset),
        .lk_taken(lk_taken), .upd_en(upd_en), .upd_addr(upd_addr),
        .upd_taken(upd_taken)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit m_trained [ENTRIES];
    int m_conf    [ENTRIES];

    function automatic int slot_of(logic [ADDR_W-1:0] a);
        return int'((a >> 1) % ENTRIES);
    endfunction

    function automatic logic model_guess(logic [ADDR_W-1:0] a, logic [OFF_W-1:0] off);
        int s = slot_of(a);
        if (m_trained[s]) return m_conf[s] >= 2;
        return off[OFF_W-1];
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENTRIES; i++) begin
            m_trained[i] = 0;
            m_conf[i]    = 0;
        end
    endtask

    task automatic model_apply(logic [ADDR_W-1:0] a, logic t);
        int s = slot_of(a);
        m_trained[s] = 1;
        if (t && m_conf[s] < 3) m_conf[s]++;
        if (!t && m_conf[s] > 0) m_conf[s]--;
    endtask

    // Drive a lookup and compare the combinational result
    task automatic look(logic [ADDR_W-1:0] a, logic [OFF_W-1:0] off, string req);
        logic exp;
        lk_addr   = a;
        lk_offset = off;
        #1;
        exp = model_guess(a, off);
        checks++;
        if (lk_taken !== exp) begin
            errors++;
            $display("FAIL %s addr=%h off=%h actual=%b expected=%b", req, a, off, lk_taken, exp);
        end
    endtask

    task automatic update(logic [ADDR_W-1:0] a, logic t);
        @(negedge clk);
        upd_en = 1'b1; upd_addr = a; upd_taken = t;
        @(posedge clk);
        model_apply(a, t);
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < ENTRIES; i++) begin
            look(ADDR_W'(2 * i), 32'hFFFF_FFF0, req);
            look(ADDR_W'(2 * i), 32'h0000_0010, req);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: all slots untrained, static direction rule
        sweep("R2_R3");

        // R5: first taken update gives counter 1 -> not taken even backward
        update(32'h0000_0006, 1'b1);
        look(32'h0000_0006, 32'hFFFF_FFFC, "R5");

        // R1: bit 0 and upper bits alias to the same slot
        update(32'h0000_0006, 1'b1);
        look(32'h0000_0007, 32'h0000_0004, "R1");
        look(32'h1234_5676, 32'h0000_0004, "R1");
        look(32'h0000_0016, 32'h0000_0004, "R1");
        look(32'h0000_0004, 32'h0000_0004, "R1");

        // R4 / R6 / R7 / R8: walk each slot up to saturation and back
        do_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            for (int k = 0; k < 5; k++) begin
                update(ADDR_W'(2 * i + 32 * k), 1'b1);
                look(ADDR_W'(2 * i), 32'hFFFF_FFF0, "R6");
                look(ADDR_W'(2 * i), 32'h0000_0010, "R4");
            end
            sweep("R8");
            for (int k = 0; k < 5; k++) begin
                update(ADDR_W'(2 * i + 1), 1'b0);
                look(ADDR_W'(2 * i), 32'hFFFF_FFF0, "R7");
                look(ADDR_W'(2 * i), 32'h0000_0010, "R4");
            end
            sweep("R8");
        end

        // R9: same-slot lookup and update in one cycle
        @(negedge clk);
        upd_en = 1'b1; upd_addr = 32'h0000_000A; upd_taken = 1'b1;
        look(32'h0000_000A, 32'hFFFF_FFF0, "R9");
        @(posedge clk);
        model_apply(32'h0000_000A, 1'b1);
        #1;
        checks++;
        if (lk_taken !== model_guess(32'h0000_000A, 32'hFFFF_FFF0)) begin
            errors++;
            $display("FAIL R9 after edge actual=%b expected=%b", lk_taken,
                     model_guess(32'h0000_000A, 32'hFFFF_FFF0));
        end
        @(negedge clk);
        upd_en = 1'b0;
        update(32'h0000_000A, 1'b1);
        look(32'h0000_000A, 32'h0000_0010, "R9");

        // R11: toggling update inputs with strobe low
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            upd_addr  = ADDR_W'(2 * c);
            upd_taken = c[0];
        end
        @(negedge clk);
        sweep("R11");

        // R10: reset while trained
        do_reset();
        sweep("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule